// File: doc/BRIEF.md
# Programmed interrupt request register

This block is a 16-bit memory-mapped register that lets software raise its own interrupts at any of seven priority levels. Each level from 1 to 7 has one request flag in the upper byte. The register's lower byte is read-only. It reports the highest pending level, encoded twice so that it can be used directly as a scaled index.

A comparator checks the highest pending level against the processor's current 3-bit priority. It presents an interrupt request, with its level, only when the pending level is strictly greater than that priority. Software sets requests by writing the upper byte, normally as a read-modify-write OR. It retires a serviced level by clearing that one flag. A request set at a level above the one being serviced therefore preempts the handler as soon as the priority is lowered, which gives nested servicing. The acknowledge input leaves the flags untouched.

Top module: `prog_irq_reg`

## Requirements
- R1: The request flag for level n (1 to 7) is register bit 8+n. Bits 15:9 of the read value are the stored flags.
- R2: With highest pending level L, the lower byte reads L in bits 7:5 and L again in bits 3:1, with bits 4 and 0 zero (value L times octal 042).
- R3: With no flag set, the lower byte reads zero and no interrupt is requested.
- R4: With several flags set, the highest-numbered one is reported on the read value and on the request level.
- R5: The request output is high only when the highest pending level is strictly greater than the processor priority. At priority 7 it is never high.
- R6: A write with the upper byte enable (wr_be[1]) loads bits 15:9 as the new flags. Clearing one flag in the written data leaves the other written flags pending.
- R7: Lower-byte writes and written bit 8 have no effect. Bit 8 always reads zero.
- R8: Asserting the acknowledge input does not change any flag.
- R9: Asynchronous active-low reset clears all flags.
- R10: The read value, request output and request level reflect a write in the cycle after the write's clock edge. A newly set higher level takes over from a lower pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables, bit 1 = upper byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register read value |
| cpu_pri | input | 3 | Current processor priority |
| irq_ack | input | 1 | Interrupt acknowledge (no effect on flags) |
| irq_valid | output | 1 | Interrupt request presented |
| irq_level | output | 3 | Highest pending level |

## Verification
Two events can fall in the same cycle: an upper-byte write that changes the flags, and a change of the processor priority that decides whether the new highest level is presented. The bench provokes this in a handler-like sequence. In one step it clears the serviced level, sets a higher one and lowers the priority. A scoreboard entry holds the expected read value, level and request, taken from a flag model, and that entry is compared one edge later. Preemption is judged the same way: a level that ties or sits below the priority must stay unpresented, and it becomes presented once the priority drops below it.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int NLEV  = 7;
  localparam int LVL_W = $clog2(NLEV + 1);
  localparam int REG_W = 16;
  localparam int FLAG_LSB = REG_W - NLEV;
  typedef logic [NLEV-1:0]  req_t;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pir_flags.sv
module pir_flags
  import pir_pkg::*;
#(
  parameter int N = NLEV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_hi,
  input  logic [N-1:0] wr_bits,
  input  logic         ack,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q, flags_nxt;
  logic         load;

  assign load = wr_en && wr_hi;

  always_comb begin
    flags_nxt = flags_q;
    if (load) flags_nxt = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= '0;
    else if (load) flags_q <= flags_nxt;
  end

  assign flags = flags_q;

  // R6
  upper_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> (flags_q == $past(wr_bits)));

  // R7
  low_only_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> $stable(flags_q));

  // R8
  ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en) |=> $stable(flags_q));
endmodule

// File: rtl/pir_prio_enc.sv
module pir_prio_enc
  import pir_pkg::*;
#(
  parameter int N = NLEV,
  parameter int W = LVL_W
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) lvl = W'(i + 1);
    end
  end
endmodule

// File: rtl/pir_readback.sv
module pir_readback
  import pir_pkg::*;
#(
  parameter int N = NLEV,
  parameter int W = LVL_W
) (
  input  logic [N-1:0]       flags,
  input  logic [W-1:0]       lvl,
  output logic [REG_W-1:0]   rd
);
  localparam int HALF = W + 1;
  logic [HALF-1:0] lvl_field;

  assign lvl_field = {lvl, 1'b0};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_copy
      assign rd[g*HALF +: HALF] = lvl_field;
    end
  endgenerate

  assign rd[FLAG_LSB-1] = 1'b0;
  assign rd[REG_W-1:FLAG_LSB] = flags;
endmodule

// File: rtl/prog_irq_reg.sv
module prog_irq_reg
  import pir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic [2:0]  cpu_pri,
  input  logic        irq_ack,
  output logic        irq_valid,
  output logic [2:0]  irq_level
);
  req_t flags;
  lvl_t top_lvl;
  logic unused_bits;

  assign unused_bits = ^{wr_data[FLAG_LSB-1:0], wr_be[0]};

  pir_flags #(.N(NLEV)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_hi   (wr_be[1]),
    .wr_bits (wr_data[REG_W-1:FLAG_LSB]),
    .ack     (irq_ack),
    .flags   (flags)
  );

  pir_prio_enc #(.N(NLEV), .W(LVL_W)) u_enc (
    .req (flags),
    .lvl (top_lvl)
  );

  pir_readback #(.N(NLEV), .W(LVL_W)) u_rb (
    .flags (flags),
    .lvl   (top_lvl),
    .rd    (rd_data)
  );

  assign irq_level = top_lvl;
  assign irq_valid = (top_lvl > cpu_pri);

  // R4
  top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (flags[irq_level - 3'd1] && ((flags >> irq_level) == '0)));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:8] == 8'h00) |-> (!irq_valid && rd_data[7:0] == 8'h00));

  // R5
  max_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pri == 3'd7) |-> !irq_valid);

  // R7
  bit8_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[8]) |=> !rd_data[8]);
endmodule

// File: tb/sim_prog_irq_reg.sv
module sim_prog_irq_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic [2:0]  cpu_pri = 3'd7;
  logic        irq_ack = 1'b0;
  logic        irq_valid;
  logic [2:0]  irq_level;

  int checks = 0;
  int errors = 0;
  logic [6:0] mflags = '0;

  typedef struct {
    logic [15:0] rd;
    logic        v;
    logic [2:0]  l;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  prog_irq_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .cpu_pri(cpu_pri),
    .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_level(irq_level)
  );

  function automatic logic [2:0] top_of(input logic [6:0] f);
    logic [2:0] l = 3'd0;
    for (int i = 0; i < 7; i++) if (f[i]) l = 3'(i + 1);
    return l;
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (rd_data !== e.rd || irq_valid !== e.v || irq_level !== e.l) begin
      errors++;
      $display("FAIL %s: rd=%h valid=%b lvl=%0d expected rd=%h valid=%b lvl=%0d",
               e.tag, rd_data, irq_valid, irq_level, e.rd, e.v, e.l);
    end
  endtask

  function automatic exp_t model(input logic [2:0] pri, input string tag);
    exp_t e;
    logic [2:0] l = top_of(mflags);
    e.rd  = {mflags, 1'b0, l, 1'b0, l, 1'b0};
    e.l   = l;
    e.v   = (l > pri);
    e.tag = tag;
    return e;
  endfunction

  // driver: apply at negedge, push expectation after the edge
  task automatic step(input bit we, input logic [1:0] be, input logic [15:0] d,
                      input logic [2:0] pri, input bit ack, input string tag);
    @(negedge clk);
    wr_en = we; wr_be = be; wr_data = d; cpu_pri = pri; irq_ack = ack;
    if (we && be[1]) mflags = d[15:9];
    @(posedge clk);
    #1;
    wr_en = 1'b0; irq_ack = 1'b0;
    sb.push_back(model(pri, tag));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    #4;
    e = model(3'd7, "R9 reset state");
    compare(e);
    @(negedge clk) rst_n = 1'b1;

    // R1 R5: levels 1 and 3 at priority 7, then 2, then 3
    step(1, 2'b10, 16'h0A00, 3'd7, 0, "R1 R5 pri7 blocks");
    step(0, 2'b00, 16'h0000, 3'd2, 0, "R5 level3 over pri2");
    step(0, 2'b00, 16'h0000, 3'd3, 0, "R5 equal pri waits");
    // R6 R10: handler clears 3 and sets 7 in the same write
    step(1, 2'b10, 16'h8200, 3'd3, 0, "R6 R10 clear3 set7");
    // R7: lower-byte-only write
    step(1, 2'b01, 16'h00FF, 3'd7, 0, "R7 low byte ignored");
    // R8: acknowledge keeps flags
    step(0, 2'b00, 16'h0000, 3'd6, 1, "R8 ack keeps flags");
    step(0, 2'b00, 16'h0000, 3'd6, 0, "R8 after ack");
    // R7 R4: all bits written, bit 8 stays zero
    step(1, 2'b11, 16'hFFFF, 3'd7, 0, "R7 R4 all set bit8 zero");
    step(1, 2'b10, 16'h7E00, 3'd5, 0, "R4 R6 clear7 keep rest");
    step(1, 2'b10, 16'h0200, 3'd0, 0, "R2 level1 encoding");
    step(1, 2'b10, 16'h0000, 3'd0, 0, "R3 none pending");
    // nested: 5 and 2 pending
    step(1, 2'b10, 16'h2400, 3'd4, 0, "R4 R10 level5 over 2");
    step(0, 2'b00, 16'h0000, 3'd5, 0, "R5 pri5 blocks");
    step(1, 2'b10, 16'h0400, 3'd5, 0, "R6 level2 remains");
    step(0, 2'b00, 16'h0000, 3'd1, 0, "R10 level2 taken");
    // R1 R2: each level alone
    for (int i = 1; i <= 7; i++) begin
      step(1, 2'b10, 16'(1) << (8 + i), 3'(i - 1), 0, "R1 R2 single level");
      step(0, 2'b00, 16'h0000, 3'(i), 0, "R5 single level at pri");
    end
    // R9: reset mid-run
    step(1, 2'b10, 16'hA800, 3'd0, 0, "R4 before reset");
    @(negedge clk) rst_n = 1'b0;
    mflags = '0;
    #2;
    e = model(3'd0, "R9 async reset clears");
    compare(e);
    @(negedge clk) rst_n = 1'b1;
    step(0, 2'b00, 16'h0000, 3'd0, 0, "R9 stays clear");

    wait (sb.size() == 0);
    @(posedge clk);
    #6;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule